// File: doc/BRIEF.md
# Daisy-Chainable Small Static RAM

This block is a 64-word by 8-bit static memory meant to sit directly on a small microprocessor bus. The word address is six bits wide: five low bits on their own pins, and a sixth pin that serves two purposes. In bus-capture mode, an address strobe holds the level of that pin while the high address byte is on a multiplexed bus. The held level then acts as one of three chip-select terms. The live level of the pin, sampled later in the cycle, is bit 5 of the word address. In plain mode the strobe is tied high, and the pin is only an ordinary sixth address bit.

Read and write strobes are active low. When both are low the write wins, so a single read/write line can drive both strobes. The data output comes with an output-enable signal in place of a three-state pin. A chain-enable output is high while the block is selected. While the block is deselected it follows the read strobe, so a device wired to it is enabled only during reads that this block does not claim.

Top module: `chainable_sram`

## Requirements
- R1: Each word address {sel_a5, addr_lo} selects its own one of 64 words of 8 bits. A selected write (wr_n low) stores din into that word on the rising clock edge.
- R2: In bus-capture mode the block is selected only when cs_a is 1, cs_b_n is 0 and the captured level is 1.
- R3: In bus-capture mode the captured level follows sel_a5 while strobe is 1. After strobe falls it holds the sel_a5 value sampled at the last rising clock edge on which strobe was 1.
- R4: In plain mode (strobe tied to 1) the block is selected when cs_a is 1 and cs_b_n is 0, whatever the level of sel_a5. In that mode sel_a5 acts only as address bit 5.
- R5: When wr_n is 0, a selected cycle writes even if rd_n is also 0, and dout_oe stays 0.
- R6: dout_oe is 1 exactly when the block is selected, rd_n is 0 and wr_n is 1. dout carries the addressed word when dout_oe is 1 and is 0 otherwise.
- R7: chain_en is 1 while the block is selected. While the block is deselected, chain_en equals rd_n.
- R8: A write cycle in which the block is not selected leaves every word unchanged.
- R9: A read of the word written on the previous clock edge returns the new data in the same cycle, with no added latency.
- R10: Reset (rst_n low) clears the captured level to 0, so a bus-capture block is deselected after reset until a 1 is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for writes and for the select capture register |
| rst_n | input | 1 | Active-low asynchronous reset of the captured level |
| addr_lo | input | 5 | Word address bits 4..0 |
| sel_a5 | input | 1 | Select level to capture, and word address bit 5 |
| cs_a | input | 1 | Active-high chip select |
| cs_b_n | input | 1 | Active-low chip select |
| strobe | input | 1 | Address strobe; the capture is transparent while it is 1 |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, overrides rd_n |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driving |
| dout_oe | output | 1 | High when dout should drive the bus |
| chain_en | output | 1 | Enable output for the next device in the chain |

## Verification
Two functions can fall in the same cycle: a write, and a read or chain hand-off. The bench provokes this by holding rd_n and wr_n low together on a selected word. It then expects dout_oe at 0 and chain_en at 1, and expects the new word to be there afterwards. A second collision occurs when a write is followed at once by a read of the same word. The read must return the data from the edge just passed. One bench instance captures the select and another has the strobe tied high. Writes made with the captured level at 0 must therefore land in one of the two copies only.

// File: rtl/sram_pkg.sv
package sram_pkg;

   typedef enum logic {
      SEL_PLAIN  = 1'b0,
      SEL_BUSCAP = 1'b1
   } sel_mode_e;

   typedef struct packed {
      logic selected;
      logic write;
      logic drive;
   } sram_ctrl_t;

endpackage

// File: rtl/sram_select_capture.sv
module sram_select_capture
   import sram_pkg::*;
#(
   parameter sel_mode_e MODE = SEL_BUSCAP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_i,
   input  logic level_i,
   output logic gate_o
);

   generate
      if (MODE == SEL_BUSCAP) begin : g_capture
         logic held_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               held_q <= 1'b0;
            else if (strobe_i)
               held_q <= level_i;
         end

         // Register plus bypass models a latch that is open while strobe is high
         assign gate_o = strobe_i ? level_i : held_q;

         assert_capture_hold_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(strobe_i) && $past(rst_n)) |-> (gate_o == $past(level_i)))
            else $error("captured level differs from sel_a5 at the strobe fall");
      end else begin : g_plain
         logic unused_in;
         assign unused_in = strobe_i ^ level_i ^ clk ^ rst_n;
         assign gate_o    = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/sram_ctrl_decode.sv
module sram_ctrl_decode
   import sram_pkg::*;
(
   input  logic       cs_a_i,
   input  logic       cs_b_n_i,
   input  logic       gate_i,
   input  logic       rd_n_i,
   input  logic       wr_n_i,
   output sram_ctrl_t ctrl_o,
   output logic       chain_o
);

   logic sel;

   always_comb begin
      sel             = cs_a_i & ~cs_b_n_i & gate_i;
      ctrl_o.selected = sel;
      ctrl_o.write    = sel & ~wr_n_i;
      ctrl_o.drive    = sel & ~rd_n_i & wr_n_i;
      chain_o         = sel | rd_n_i;
   end

endmodule

// File: rtl/sram_word_array.sv
module sram_word_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i)
         mem[addr_i] <= wdata_i;
   end

   assign rdata_o = mem[addr_i];

   assert_write_lands_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem[$past(addr_i)] == $past(wdata_i)))
      else $error("written word does not hold the write data");

   assert_idle_keeps_word_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!we_i && $past(rst_n)) |=> (mem[$past(addr_i)] == $past(rdata_o)))
      else $error("word changed without a selected write");

endmodule

// File: rtl/chainable_sram.sv
module chainable_sram
   import sram_pkg::*;
#(
   parameter sel_mode_e MODE   = SEL_BUSCAP,
   parameter int        ADDR_W = 6,
   parameter int        DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-2:0] addr_lo,
   input  logic              sel_a5,
   input  logic              cs_a,
   input  logic              cs_b_n,
   input  logic              strobe,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   output logic              chain_en
);

   localparam int LO_W = ADDR_W - 1;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 12) else $error("ADDR_W out of range");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic              gate;
   sram_ctrl_t        ctrl;
   logic [ADDR_W-1:0] word_addr;
   logic [DATA_W-1:0] rdata;

   assign word_addr = {sel_a5, addr_lo[LO_W-1:0]};

   sram_select_capture #(.MODE(MODE)) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe_i(strobe),
      .level_i (sel_a5),
      .gate_o  (gate)
   );

   sram_ctrl_decode u_decode (
      .cs_a_i  (cs_a),
      .cs_b_n_i(cs_b_n),
      .gate_i  (gate),
      .rd_n_i  (rd_n),
      .wr_n_i  (wr_n),
      .ctrl_o  (ctrl),
      .chain_o (chain_en)
   );

   sram_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_i   (ctrl.write),
      .addr_i (word_addr),
      .wdata_i(din),
      .rdata_o(rdata)
   );

   assign dout_oe = ctrl.drive;
   assign dout    = ctrl.drive ? rdata : '0;

   assert_write_beats_read_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> !dout_oe)
      else $error("output driven during a write");

   assert_chain_on_drive_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> chain_en)
      else $error("chain enable low while this block drives data");

   assert_quiet_bus_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> (dout == '0))
      else $error("dout not zero while released");

endmodule

// File: tb/tb_chainable_sram.sv
module tb_chainable_sram;
   import sram_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] a_lo = '0;
   logic       a5 = 1'b0;
   logic       stb = 1'b0;
   logic       cs1 = 1'b0;
   logic       cs2n = 1'b1;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] din = '0;

   logic [7:0] dout_c, dout_p;
   logic       oe_c, oe_p, ch_c, ch_p;

   always #5 clk = ~clk;

   chainable_sram #(.MODE(SEL_BUSCAP)) dut (
      .clk(clk), .rst_n(rst_n), .addr_lo(a_lo), .sel_a5(a5), .cs_a(cs1),
      .cs_b_n(cs2n), .strobe(stb), .rd_n(rd_n), .wr_n(wr_n), .din(din),
      .dout(dout_c), .dout_oe(oe_c), .chain_en(ch_c));

   chainable_sram #(.MODE(SEL_PLAIN)) dut_flat (
      .clk(clk), .rst_n(rst_n), .addr_lo(a_lo), .sel_a5(a5), .cs_a(cs1),
      .cs_b_n(cs2n), .strobe(1'b1), .rd_n(rd_n), .wr_n(wr_n), .din(din),
      .dout(dout_p), .dout_oe(oe_p), .chain_en(ch_p));

   int checks = 0;
   int errors = 0;
   logic [7:0] m_c [64];
   logic [7:0] m_p [64];
   logic       cap = 1'b0;
   bit         done = 1'b0;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic capture(input logic v);
      @(negedge clk);
      stb = 1'b1; a5 = v;
      @(posedge clk);
      @(negedge clk);
      stb = 1'b0;
      cap = v;
   endtask

   task automatic wr(input int addr, input logic [7:0] d);
      @(negedge clk);
      a_lo = addr[4:0]; a5 = addr[5]; din = d; wr_n = 1'b0; rd_n = 1'b1;
      @(posedge clk);
      if (cs1 && !cs2n && cap) m_c[addr] = d;
      if (cs1 && !cs2n)        m_p[addr] = d;
      @(negedge clk);
      wr_n = 1'b1;
   endtask

   task automatic rdchk(input int addr, input string req);
      logic sc, sp;
      @(negedge clk);
      a_lo = addr[4:0]; a5 = addr[5]; rd_n = 1'b0; wr_n = 1'b1;
      #1;
      sc = cs1 && !cs2n && cap;
      sp = cs1 && !cs2n;
      chk({req, " capture oe"}, oe_c, sc);
      chk({req, " capture dout"}, dout_c, sc ? m_c[addr] : 8'h00);
      chk({req, " plain oe"}, oe_p, sp);
      chk({req, " plain dout"}, dout_p, sp ? m_p[addr] : 8'h00);
      rd_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : stim
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state, capture copy deselected, plain copy selected
      cs1 = 1'b1; cs2n = 1'b0; rd_n = 1'b0;
      #1;
      chk("R10 chain after reset", ch_c, 0);
      chk("R10 oe after reset", oe_c, 0);
      chk("R4 plain chain after reset", ch_p, 1);
      rd_n = 1'b1;

      // R1: fill and read back every word in both copies
      capture(1'b1);
      for (int a = 0; a < 64; a++) wr(a, 8'((a * 29 + 7) & 255));
      for (int a = 0; a < 64; a++) rdchk(a, "R1");

      // R8: unselected write leaves memory unchanged
      cs1 = 1'b0;
      wr(10, 8'hAA);
      cs1 = 1'b1; cs2n = 1'b1;
      wr(11, 8'hBB);
      cs2n = 1'b0;
      rdchk(10, "R8");
      rdchk(11, "R8");

      // R4/R2: captured 0 blocks capture copy only
      capture(1'b0);
      wr(37, 8'h55);
      rdchk(37, "R2");
      capture(1'b1);
      rdchk(37, "R4");
      chk("R4 plain word stored", m_p[37], 8'h55);

      // R3: transparency while strobe high, hold after fall
      @(negedge clk);
      stb = 1'b1; a5 = 1'b0; rd_n = 1'b0; a_lo = 5'd3;
      #1;
      chk("R3 transparent low", ch_c, 0);
      a5 = 1'b1;
      #1;
      chk("R3 transparent high", ch_c, 1);
      @(posedge clk);
      @(negedge clk);
      stb = 1'b0; a5 = 1'b0;
      #1;
      cap = 1'b1;
      chk("R3 held after fall", ch_c, 1);
      chk("R3 held read oe", oe_c, 1);
      chk("R3 held read data", dout_c, m_c[3]);
      rd_n = 1'b1;

      // R5: write overrides read
      @(negedge clk);
      a_lo = 5'd20; a5 = 1'b1; din = 8'hC3; wr_n = 1'b0; rd_n = 1'b0;
      #1;
      chk("R5 oe capture during write", oe_c, 0);
      chk("R5 oe plain during write", oe_p, 0);
      chk("R5 chain during write", ch_c, 1);
      @(posedge clk);
      m_c[52] = 8'hC3; m_p[52] = 8'hC3;
      // R9: read right after the write edge
      #1;
      wr_n = 1'b1;
      #1;
      chk("R9 read after write", dout_c, 8'hC3);
      chk("R9 read after write plain", dout_p, 8'hC3);
      @(negedge clk);
      rd_n = 1'b1;
      rdchk(52, "R5");

      // R6/R7: sweep select terms and strobes
      for (int c = 0; c < 32; c++) begin
         logic v1, v2n, vc, vr, vw, sc, sp;
         v1 = c[0]; v2n = c[1]; vc = c[2]; vr = c[3]; vw = c[4];
         capture(vc);
         @(negedge clk);
         cs1 = v1; cs2n = v2n; rd_n = vr; wr_n = vw; a_lo = 5'd7; a5 = 1'b0;
         #1;
         sc = v1 && !v2n && vc;
         sp = v1 && !v2n;
         chk("R7 chain capture", ch_c, sc | vr);
         chk("R7 chain plain", ch_p, sp | vr);
         chk("R6 oe capture", oe_c, sc & !vr & vw);
         chk("R6 oe plain", oe_p, sp & !vr & vw);
         chk("R6 dout capture", dout_c, (sc & !vr & vw) ? m_c[7] : 8'h00);
         wr_n = 1'b1; rd_n = 1'b1;
      end

      finish_run();
   end

endmodule